// File: doc/BRIEF.md
# Coded-Ratio Comparison-Frequency Divider

This block divides a reference clock down to the comparison rate fed to a phase detector. A 5-bit ratio code picks one of 29 legal division ratios. Each ratio is a base of 1, 5, 6 or 7 times a power of two. The two upper code bits pick the base and the three lower bits pick the exponent. Three codes have no ratio and are flagged as illegal.

For each divided period the block emits a pulse one reference cycle wide. For even ratios it also emits a square wave whose duty cycle is exactly 50 %. A new code is taken up only at the end of the period in progress, so the output never shows a short period. An illegal code stops the output at once. Both outputs are held low until a legal code returns, and counting then restarts from zero.

Top module: `refdiv_top`

## Requirements
- R1: With code bits [4:3] = 00, the pulse period in reference cycles is 2^(code[2:0]+1), giving 2, 4, 8, 16, 32, 64, 128 and 256 for codes 0 to 7.
- R2: With code bits [4:3] = g (1, 2 or 3) and code[2:0] = s from 1 to 7, the pulse period is (4+g)·2^(s-1). Group 01 gives 5 to 320, group 10 gives 6 to 384 and group 11 gives 7 to 448.
- R3: Codes 01000, 10000 and 11000 are illegal. `code_bad` is high from the clock edge after such a code is sampled.
- R4: While `code_bad` is high, `cmp_pulse` and `cmp_half` are both low, and no pulse comes out while an illegal code is applied.
- R5: `rst` is synchronous and active high. During reset both outputs are low. With ratio N, the first pulse comes at the Nth rising edge after reset is released, and every pulse is one cycle wide.
- R6: A change between legal codes takes effect at the next terminal count. The period in progress completes with the old ratio, and the following period uses the new one.
- R7: When a legal code follows an illegal one, the edge that first samples the legal code clears the counter. The first pulse then comes N edges later.
- R8: For an even ratio N, `cmp_half` is high for the last N/2 cycles of each period and falls in the cycle in which `cmp_pulse` is high. For odd ratios `cmp_half` stays low.
- R9: `code_bad` is low for every legal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 5 | Division ratio code |
| cmp_pulse | output | 1 | One-cycle pulse per divided period |
| cmp_half | output | 1 | 50 % comparison clock (even ratios only) |
| code_bad | output | 1 | Registered illegal-code flag |

## Verification
The bench sweeps all 32 codes and measures each pulse period and the high time of the half-rate clock. A decode that used the wrong exponent offset would show a period off by a factor of two. One bench check changes the code partway through a period. A divider that reloaded at once would give a short or irregular period there, not the old period followed by the new one. The bench also times recovery from an illegal code and the first pulse after reset. A counter that did not restart from zero would give an early first pulse.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W = 5;
  localparam int GRP_W  = 2;
  localparam int SEL_W  = CODE_W - GRP_W;
  localparam int BASE_W = 4;
  localparam int RAT_W  = 9;

  typedef struct packed {
    logic             legal;
    logic [RAT_W-1:0] ratio;
  } ratio_t;
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output ratio_t            dec_o
);
  logic [GRP_W-1:0]  grp;
  logic [SEL_W-1:0]  sel;
  logic [BASE_W-1:0] base;
  logic [SEL_W:0]    shamt;

  always_comb begin
    grp = code_i[CODE_W-1 -: GRP_W];
    sel = code_i[SEL_W-1:0];
    if (grp == '0) begin
      base  = BASE_W'(1);
      shamt = {1'b0, sel} + 1'b1;
    end else begin
      base  = BASE_W'(4) + BASE_W'(grp);
      shamt = {1'b0, sel} - 1'b1;
    end
    dec_o.legal = (grp == '0) || (sel != '0);
    dec_o.ratio = dec_o.legal ? (RAT_W'(base) << shamt) : '0;
  end
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core #(
  parameter int RAT_W   = 9,
  parameter bit HALF_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legal_i,
  input  logic [RAT_W-1:0] ratio_i,
  output logic             pulse_o,
  output logic             half_o
);
  logic [RAT_W-1:0] cnt_q, cnt_n;
  logic [RAT_W-1:0] rat_q, rat_n;
  logic             halt_q, halt_n;
  logic             pls_q, pls_n;
  logic             half_q, half_n;
  logic             tc;

  assign tc = (cnt_q == rat_q - RAT_W'(1));

  always_comb begin
    cnt_n  = cnt_q;
    rat_n  = rat_q;
    halt_n = halt_q;
    pls_n  = 1'b0;
    if (!legal_i) begin
      halt_n = 1'b1;
      cnt_n  = '0;
    end else if (halt_q) begin
      halt_n = 1'b0;
      rat_n  = ratio_i;
      cnt_n  = '0;
    end else if (tc) begin
      cnt_n  = '0;
      pls_n  = 1'b1;
      rat_n  = ratio_i;
    end else begin
      cnt_n  = cnt_q + RAT_W'(1);
    end
  end

  generate
    if (HALF_EN) begin : g_half
      assign half_n = !halt_n && !rat_n[0] && (cnt_n >= (rat_n >> 1));
    end else begin : g_nohalf
      assign half_n = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rat_q  <= ratio_i;
      halt_q <= !legal_i;
      pls_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rat_q  <= rat_n;
      halt_q <= halt_n;
      pls_q  <= pls_n;
      half_q <= half_n;
    end
  end

  assign pulse_o = pls_q;
  assign half_o  = half_q;

  // R6: the running count never reaches the loaded ratio
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    !halt_q |-> (cnt_q < rat_q));
  // R6: the loaded ratio moves only at a terminal count or a restart
  a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
    (!halt_q && $past(!halt_q) && !pls_q) |-> $stable(rat_q));
  a_r5_pulse_one_wide: assert property (@(posedge clk) disable iff (rst)
    pls_q |=> !pls_q);
  a_r8_half_low_at_pulse: assert property (@(posedge clk) disable iff (rst)
    pls_q |-> !half_q);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              cmp_pulse,
  output logic              cmp_half,
  output logic              code_bad
);
  ratio_t dec;
  logic   bad_q;

  refdiv_decode u_dec (
    .code_i (ratio_code),
    .dec_o  (dec)
  );

  refdiv_core #(.RAT_W(RAT_W), .HALF_EN(HALF_EN)) u_core (
    .clk     (clk),
    .rst     (rst),
    .legal_i (dec.legal),
    .ratio_i (dec.ratio),
    .pulse_o (cmp_pulse),
    .half_o  (cmp_half)
  );

  always_ff @(posedge clk) begin
    bad_q <= !dec.legal;
  end

  assign code_bad = bad_q;

  a_r4_quiet_on_bad: assert property (@(posedge clk) disable iff (rst)
    code_bad |-> (!cmp_pulse && !cmp_half));
  a_r3_flag_on_bad_code: assert property (@(posedge clk) disable iff (rst)
    ((ratio_code[CODE_W-1 -: GRP_W] != '0) && (ratio_code[SEL_W-1:0] == '0)) |=> code_bad);
  a_r9_flag_clear_group0: assert property (@(posedge clk) disable iff (rst)
    (ratio_code[CODE_W-1 -: GRP_W] == '0) |=> !code_bad);
endmodule

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] code = 5'b00010;
  logic       cmp_pulse, cmp_half, code_bad;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  refdiv_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .ratio_code (code),
    .cmp_pulse  (cmp_pulse),
    .cmp_half   (cmp_half),
    .code_bad   (code_bad)
  );

  always #10 clk = ~clk;

  function automatic bit is_bad(logic [4:0] c);
    return (c[4:3] != 2'b00) && (c[2:0] == 3'b000);
  endfunction

  function automatic int ratio_of(logic [4:0] c);
    int g = int'(c[4:3]);
    int s = int'(c[2:0]);
    if (g == 0) return 1 << (s + 1);
    return (4 + g) << (s - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference model
  int m_cnt = 0, m_rat = 8;
  bit m_halt = 0, m_p = 0, m_h = 0, m_b = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_rat = ratio_of(code); m_halt = is_bad(code); m_cnt = 0;
      m_p = 0; m_h = 0; m_b = is_bad(code);
    end else begin
      m_b = is_bad(code);
      m_p = 0;
      if (is_bad(code)) begin
        m_halt = 1; m_cnt = 0;
      end else if (m_halt) begin
        m_halt = 0; m_rat = ratio_of(code); m_cnt = 0;
      end else if (m_cnt == m_rat - 1) begin
        m_cnt = 0; m_p = 1; m_rat = ratio_of(code);
      end else begin
        m_cnt++;
      end
      m_h = !m_halt && (m_rat % 2 == 0) && (m_cnt >= m_rat / 2);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cmp_pulse == m_p, "R5 model pulse", cmp_pulse, m_p);
      chk(cmp_half == m_h, "R8 model half", cmp_half, m_h);
      chk(code_bad == m_b, "R3 model flag", code_bad, m_b);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmp_pulse && n < 2000);
  endtask

  task automatic measure(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk);
      n++;
      if (cmp_half) hi++;
    end while (!cmp_pulse && n < 2000);
  endtask

  initial begin
    int n, hi, pcount;
    repeat (4) @(negedge clk);
    // reset state (R5)
    chk(cmp_pulse == 0, "R5 reset pulse", cmp_pulse, 0);
    chk(cmp_half == 0, "R5 reset half", cmp_half, 0);
    chk(code_bad == 0, "R9 reset flag", code_bad, 0);
    rst = 1'b0;
    wait_pulse(n);
    chk(n == 8, "R5 first pulse after reset", n, 8);

    // sweep all codes: R1, R2, R3, R4, R8, R9
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      code = 5'(c);
      if (is_bad(code)) begin
        @(negedge clk);
        chk(code_bad == 1, "R3 illegal flag", code_bad, 1);
        pcount = 0;
        for (int k = 0; k < 20; k++) begin
          if (cmp_pulse || cmp_half) pcount++;
          @(negedge clk);
        end
        chk(pcount == 0, "R4 quiet on illegal", pcount, 0);
      end else begin
        wait_pulse(n);
        measure(n, hi);
        if (c < 8) chk(n == ratio_of(code), "R1 period", n, ratio_of(code));
        else       chk(n == ratio_of(code), "R2 period", n, ratio_of(code));
        chk(hi == ((n % 2 == 0) ? n / 2 : 0), "R8 half high time", hi,
            (ratio_of(code) % 2 == 0) ? ratio_of(code) / 2 : 0);
        chk(code_bad == 0, "R9 flag clear", code_bad, 0);
      end
    end

    // R6: change mid-period, old period completes, then new
    @(negedge clk); code = 5'b00010;
    wait_pulse(n); wait_pulse(n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) code = 5'b01001;
    end while (!cmp_pulse && n < 2000);
    chk(n == 8, "R6 old period completes", n, 8);
    measure(n, hi);
    chk(n == 5, "R6 new period used", n, 5);
    chk(hi == 0, "R8 odd ratio half low", hi, 0);

    // R7: recovery from illegal code (load edge plus N edges)
    @(negedge clk); code = 5'b01000;
    repeat (5) @(negedge clk);
    code = 5'b00001;
    wait_pulse(n);
    chk(n == 5, "R7 restart timing", n, 5);
    measure(n, hi);
    chk(n == 4, "R7 period after restart", n, 4);

    // R4: illegal code mid-period silences at once
    @(negedge clk); code = 5'b00111;
    wait_pulse(n); wait_pulse(n);
    repeat (10) @(negedge clk);
    code = 5'b11000;
    @(negedge clk);
    chk(cmp_half == 0, "R4 half low after illegal", cmp_half, 0);
    chk(code_bad == 1, "R3 flag mid-period", code_bad, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule